// File: doc/BRIEF.md
# Prioritized interrupt request controller

This block gathers interrupt requests from forty-one peripheral and external sources, gives each of them a priority level, and names a single winner among the ones that are waiting. Fifteen external request lines and the non-maskable line have fixed priorities. The on-chip peripherals take their levels from three 16-bit priority registers written over a simple memory-mapped port. A single 4-bit field in one of those registers can set the level of a whole group of related sources at once.

A request pulse on a source records it as waiting. A clear pulse removes it. The block always presents the exception code of the current winner, together with a flag that says whether anything is waiting at all. It also drives a request line to the processor. That line is raised only when the processor is not blocking interrupts and its current 4-bit mask level is below the winner's level. The winner and the request line are combinational on the waiting set, the priorities, the mask and the block bit, so a change of mask or block takes effect in the same cycle.

Top module: `intc_prio`

## Requirements
- R1: A raise pulse on a source whose current priority is 0 leaves that source not waiting. A later write that gives it a non-zero level does not make it wait.
- R2: Register A (offset 0x004) sets levels as follows. Bits 15:12 set timer channel 0 (source 23). Bits 11:8 set timer channel 1 (24). Bits 7:4 set both timer channel 2 sources (25, 26). Bits 3:0 set the three real-time-clock sources (27 to 29).
- R3: Register B (offset 0x008) sets levels as follows. Bits 15:12 set the watchdog (38). Bits 11:8 set both memory-refresh sources (39, 40). Bits 7:4 set the four serial-port sources (30 to 33). Bits 3:0 are stored but drive no level.
- R4: Register C (offset 0x00C) sets levels as follows. Bits 15:12 set the general-purpose I/O source (17). Bits 11:8 set the four DMA-completion sources and the DMA-error source (18 to 22). Bits 7:4 set the four FIFO serial sources (34 to 37). Bits 3:0 set the debug-port source (16).
- R5: The winner is the waiting source with the highest level. Among waiting sources of equal level, the lowest source index wins.
- R6: `irq_req` is high exactly when a source is waiting, `cpu_block` is 0, and `cpu_mask` is strictly below the winner's level. It follows `cpu_mask` and `cpu_block` in the same cycle.
- R7: Each source has a fixed 12-bit code. External line n (0 to 14) uses 0x200 + 0x20*n. The non-maskable line uses 0x1C0. Sources 16 to 22 use 0x600 + 0x20*(i-16). Sources 23 to 33 use 0x400 + 0x20*(i-23). Sources 34 to 37 use 0x700 + 0x20*(i-34). Sources 38 to 40 use 0x560 + 0x20*(i-38).
- R8: After reset, external line n has level 15-n, the non-maskable line (source 15) has level 16, and every register-driven source has level 0. All three registers read 0.
- R9: Raising a source that is already waiting records it only once, so a single clear removes it. When a raise and a clear reach the same source in the same cycle, the clear wins.
- R10: Register decode uses only address bits 11:0. A read returns the last value written to that register, and an unmapped offset reads 0.
- R11: When nothing is waiting, `win_valid` is 0, `win_code` is 0 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_raise | input | 41 | One-cycle request pulse per source |
| src_clear | input | 41 | One-cycle clear pulse per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 32 | Register address; only bits 11:0 are decoded |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cpu_mask | input | 4 | Processor interrupt mask level |
| cpu_block | input | 1 | Processor interrupt block bit |
| win_valid | output | 1 | Some source is waiting |
| win_code | output | 12 | Exception code of the winner |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
A raise, clear or register write takes effect at the first rising edge after it is applied, and the winner, code and request line reflect it at once from that edge. Changes of mask, block bit or read address show within the same cycle. The driver therefore applies every stimulus on a falling edge. For edge-registered effects, it queues the expected winner, request and read data one edge later. For combinational effects, it queues them a short delay after the change. The monitor compares the queued values against the outputs at that same moment, while inputs are held.

// File: rtl/intc_prio_pkg.sv
package intc_prio_pkg;

   localparam int NSRC       = 41;
   localparam int PRI_W      = 5;
   localparam int NIB_W      = 4;
   localparam int REG_W      = 16;
   localparam int NREG       = 3;
   localparam int CODE_W     = 12;
   localparam int IDX_W      = $clog2(NSRC);
   localparam int NIB_PER    = REG_W / NIB_W;
   localparam int SLOT_FIXED = NREG * NIB_PER;

   // source index map (index order is the tie-break order)
   localparam int SRC_EXT_LAST = 14;
   localparam int SRC_NMI      = 15;
   localparam int SRC_DEBUG    = 16;
   localparam int SRC_GPIO     = 17;
   localparam int SRC_DMA_LO   = 18;
   localparam int SRC_DMA_HI   = 22;
   localparam int SRC_TMR0     = 23;
   localparam int SRC_TMR1     = 24;
   localparam int SRC_TMR2_LO  = 25;
   localparam int SRC_TMR2_HI  = 26;
   localparam int SRC_RTC_LO   = 27;
   localparam int SRC_RTC_HI   = 29;
   localparam int SRC_SER_LO   = 30;
   localparam int SRC_SER_HI   = 33;
   localparam int SRC_FIFO_LO  = 34;
   localparam int SRC_FIFO_HI  = 37;
   localparam int SRC_WDOG     = 38;
   localparam int SRC_REF_LO   = 39;
   localparam int SRC_REF_HI   = 40;

   typedef logic [PRI_W-1:0]  pri_t;
   typedef logic [CODE_W-1:0] code_t;
   typedef logic [REG_W-1:0]  word_t;

   // register nibble that drives a source: reg*NIB_PER + nibble, nibble 3 = bits 15:12
   function automatic int slot_of(input int s);
      if (s == SRC_TMR0)                               return 3;
      if (s == SRC_TMR1)                               return 2;
      if (s >= SRC_TMR2_LO && s <= SRC_TMR2_HI)        return 1;
      if (s >= SRC_RTC_LO  && s <= SRC_RTC_HI)         return 0;
      if (s == SRC_WDOG)                               return 7;
      if (s >= SRC_REF_LO  && s <= SRC_REF_HI)         return 6;
      if (s >= SRC_SER_LO  && s <= SRC_SER_HI)         return 5;
      if (s == SRC_GPIO)                               return 11;
      if (s >= SRC_DMA_LO  && s <= SRC_DMA_HI)         return 10;
      if (s >= SRC_FIFO_LO && s <= SRC_FIFO_HI)        return 9;
      if (s == SRC_DEBUG)                              return 8;
      return SLOT_FIXED;
   endfunction

   // level of a source that no register drives
   function automatic pri_t fixed_pri(input int s);
      if (s <= SRC_EXT_LAST) return pri_t'(15 - s);
      if (s == SRC_NMI)      return pri_t'(16);
      return '0;
   endfunction

   function automatic code_t code_of(input int s);
      if (s <= SRC_EXT_LAST)                   return code_t'(12'h200 + 32 * s);
      if (s == SRC_NMI)                        return code_t'(12'h1C0);
      if (s <= SRC_DMA_HI)                     return code_t'(12'h600 + 32 * (s - SRC_DEBUG));
      if (s <= SRC_SER_HI)                     return code_t'(12'h400 + 32 * (s - SRC_TMR0));
      if (s <= SRC_FIFO_HI)                    return code_t'(12'h700 + 32 * (s - SRC_FIFO_LO));
      return code_t'(12'h560 + 32 * (s - SRC_WDOG));
   endfunction

endpackage

// File: rtl/intc_prio_regs.sv
module intc_prio_regs
   import intc_prio_pkg::*;
#(
   parameter int                ADDR_W = 32,
   parameter int                DEC_W  = 12,
   parameter logic [DEC_W-1:0]  OFFS_A = 'h004,
   parameter logic [DEC_W-1:0]  OFFS_B = 'h008,
   parameter logic [DEC_W-1:0]  OFFS_C = 'h00C
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [ADDR_W-1:0]      addr,
   input  word_t                  wdata,
   output word_t                  rdata,
   output logic [NSRC-1:0][PRI_W-1:0] pri_vec
);

   localparam logic [NREG-1:0][DEC_W-1:0] OFFS_TAB = {OFFS_C, OFFS_B, OFFS_A};

   if (DEC_W >= ADDR_W) begin : g_bad_dec
      $error("intc_prio_regs: DEC_W must be narrower than ADDR_W");
   end
   if (OFFS_A == OFFS_B || OFFS_B == OFFS_C || OFFS_A == OFFS_C) begin : g_bad_offs
      $error("intc_prio_regs: register offsets must differ");
   end
   if (PRI_W <= NIB_W) begin : g_bad_pri
      $error("intc_prio_regs: level field must be wider than a nibble");
   end

   logic [DEC_W-1:0]          low_addr;
   logic                      unused_addr_hi;
   logic [NREG-1:0]           hit;
   word_t [NREG-1:0]          regs_q;

   assign low_addr       = addr[DEC_W-1:0];
   assign unused_addr_hi = ^addr[ADDR_W-1:DEC_W];

   for (genvar k = 0; k < NREG; k++) begin : g_hit
      assign hit[k] = (low_addr == OFFS_TAB[k]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else if (wr) begin
         for (int k = 0; k < NREG; k++) begin
            if (hit[k]) regs_q[k] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NREG; k++) begin
         if (hit[k]) rdata = regs_q[k];
      end
   end

   // level fan-out: each source either follows a register nibble or a fixed level
   for (genvar s = 0; s < NSRC; s++) begin : g_fan
      localparam int SL = slot_of(s);
      if (SL == SLOT_FIXED) begin : g_fixed
         assign pri_vec[s] = fixed_pri(s);
      end else begin : g_reg
         localparam int RG = SL / NIB_PER;
         localparam int NB = SL % NIB_PER;
         assign pri_vec[s] = {{(PRI_W-NIB_W){1'b0}}, regs_q[RG][NB*NIB_W +: NIB_W]};
      end
   end

   AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr ##1 $stable(addr)) |-> $stable(rdata)) else $error("read data moved without write"); // R10

endmodule

// File: rtl/intc_prio_pending.sv
module intc_prio_pending
   import intc_prio_pkg::*;
#(
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NSRC-1:0]            raise,
   input  logic [NSRC-1:0]            clear,
   input  logic [NSRC-1:0][PRI_W-1:0] pri_vec,
   output logic [NSRC-1:0]            pend_q
);

   logic [NSRC-1:0] set_ok;
   logic [NSRC-1:0] pend_nxt;

   for (genvar s = 0; s < NSRC; s++) begin : g_set
      assign set_ok[s] = raise[s] && (pri_vec[s] != '0);

      AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!pend_q[s] && pri_vec[s] == '0) |=> !pend_q[s]) else $error("masked source became pending"); // R1
   end

   if (CLEAR_WINS) begin : g_clr_first
      assign pend_nxt = (pend_q | set_ok) & ~clear;
      for (genvar s = 0; s < NSRC; s++) begin : g_chk
         AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            clear[s] |=> !pend_q[s]) else $error("cleared source still pending"); // R9
      end
   end else begin : g_set_first
      assign pend_nxt = (pend_q & ~clear) | set_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_nxt;
   end

endmodule

// File: rtl/intc_prio_arbiter.sv
module intc_prio_arbiter
   import intc_prio_pkg::*;
(
   input  logic [NSRC-1:0]            pend,
   input  logic [NSRC-1:0][PRI_W-1:0] pri_vec,
   output logic                       valid,
   output logic [IDX_W-1:0]           idx,
   output pri_t                       pri,
   output code_t                      code
);

   code_t [NSRC-1:0] code_tab;

   for (genvar s = 0; s < NSRC; s++) begin : g_code
      assign code_tab[s] = code_of(s);
   end

   // scan downward with >= so that a lower index takes over on an equal level
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      pri   = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend[i] && (!valid || pri_vec[i] >= pri)) begin
            valid = 1'b1;
            pri   = pri_vec[i];
            idx   = IDX_W'(i);
         end
      end
   end

   assign code = valid ? code_tab[idx] : '0;

endmodule

// File: rtl/intc_prio_gate.sv
module intc_prio_gate
   import intc_prio_pkg::*;
#(
   parameter int MASK_W = 4
) (
   input  logic              valid,
   input  pri_t              pri,
   input  logic [MASK_W-1:0] mask,
   input  logic              block,
   output logic              irq
);

   if (MASK_W >= PRI_W) begin : g_bad_mask
      $error("intc_prio_gate: mask must be narrower than the level field");
   end

   pri_t mask_ext;
   assign mask_ext = {{(PRI_W-MASK_W){1'b0}}, mask};
   assign irq      = valid && !block && (mask_ext < pri);

endmodule

// File: rtl/intc_prio.sv
module intc_prio
   import intc_prio_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                DEC_W      = 12,
   parameter int                MASK_W     = 4,
   parameter logic [DEC_W-1:0]  OFFS_A     = 'h004,
   parameter logic [DEC_W-1:0]  OFFS_B     = 'h008,
   parameter logic [DEC_W-1:0]  OFFS_C     = 'h00C,
   parameter bit                CLEAR_WINS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NSRC-1:0]     src_raise,
   input  logic [NSRC-1:0]     src_clear,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   input  logic [MASK_W-1:0]   cpu_mask,
   input  logic                cpu_block,
   output logic                win_valid,
   output logic [CODE_W-1:0]   win_code,
   output logic                irq_req
);

   logic [NSRC-1:0][PRI_W-1:0] pri_vec;
   logic [NSRC-1:0]            pend_q;
   logic [IDX_W-1:0]           win_idx;
   pri_t                       win_pri;

   intc_prio_regs #(
      .ADDR_W (ADDR_W),
      .DEC_W  (DEC_W),
      .OFFS_A (OFFS_A),
      .OFFS_B (OFFS_B),
      .OFFS_C (OFFS_C)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .rdata   (bus_rdata),
      .pri_vec (pri_vec)
   );

   intc_prio_pending #(
      .CLEAR_WINS (CLEAR_WINS)
   ) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .raise   (src_raise),
      .clear   (src_clear),
      .pri_vec (pri_vec),
      .pend_q  (pend_q)
   );

   intc_prio_arbiter u_arb (
      .pend    (pend_q),
      .pri_vec (pri_vec),
      .valid   (win_valid),
      .idx     (win_idx),
      .pri     (win_pri),
      .code    (win_code)
   );

   intc_prio_gate #(
      .MASK_W (MASK_W)
   ) u_gate (
      .valid (win_valid),
      .pri   (win_pri),
      .mask  (cpu_mask),
      .block (cpu_block),
      .irq   (irq_req)
   );

   AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> pend_q[win_idx]) else $error("winner not pending"); // R5
   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == '0) |-> (!win_valid && !irq_req && win_code == '0)) else $error("output with nothing pending"); // R11
   AST_IRQ_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (!cpu_block && win_valid)) else $error("request while blocked"); // R6

endmodule

// File: tb/intc_prio_test.sv
`timescale 1ns/100ps
module intc_prio_test;

   localparam int N = 41;

   typedef struct {
      string       tag;
      logic        valid;
      logic [11:0] code;
      logic        irq;
      bit          chk_rd;
      logic [15:0] rd;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] src_raise = '0;
   logic [N-1:0] src_clear = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  cpu_mask = '0;
   logic        cpu_block = 1'b0;
   logic        win_valid;
   logic [11:0] win_code;
   logic        irq_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   exp_t sb[$];

   int          m_pri [N];
   bit          m_pend[N];
   logic [15:0] m_reg [3];

   always #2.5 clk = ~clk;

   intc_prio uut (
      .clk(clk), .rst_n(rst_n), .src_raise(src_raise), .src_clear(src_clear),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_mask(cpu_mask), .cpu_block(cpu_block), .win_valid(win_valid),
      .win_code(win_code), .irq_req(irq_req)
   );

   // expected codes, written per group from R7
   function automatic logic [11:0] exp_code(input int s);
      if (s < 15)  return 12'(12'h200 + 12'h20 * s);
      if (s == 15) return 12'h1C0;
      if (s < 23)  return 12'(12'h600 + 12'h20 * (s - 16));
      if (s < 34)  return 12'(12'h400 + 12'h20 * (s - 23));
      if (s < 38)  return 12'(12'h700 + 12'h20 * (s - 34));
      return 12'(12'h560 + 12'h20 * (s - 38));
   endfunction

   // levels from registers per R2, R3, R4
   function automatic void apply_regs();
      m_pri[23] = int'(m_reg[0][15:12]);
      m_pri[24] = int'(m_reg[0][11:8]);
      for (int s = 25; s <= 26; s++) m_pri[s] = int'(m_reg[0][7:4]);
      for (int s = 27; s <= 29; s++) m_pri[s] = int'(m_reg[0][3:0]);
      m_pri[38] = int'(m_reg[1][15:12]);
      for (int s = 39; s <= 40; s++) m_pri[s] = int'(m_reg[1][11:8]);
      for (int s = 30; s <= 33; s++) m_pri[s] = int'(m_reg[1][7:4]);
      m_pri[17] = int'(m_reg[2][15:12]);
      for (int s = 18; s <= 22; s++) m_pri[s] = int'(m_reg[2][11:8]);
      for (int s = 34; s <= 37; s++) m_pri[s] = int'(m_reg[2][7:4]);
      m_pri[16] = int'(m_reg[2][3:0]);
   endfunction

   function automatic logic [15:0] exp_rd(input logic [31:0] a);
      case (a[11:0])
         12'h004: return m_reg[0];
         12'h008: return m_reg[1];
         12'h00C: return m_reg[2];
         default: return 16'h0000;
      endcase
   endfunction

   task automatic check(input string tag);
      exp_t e;
      int best = -1;
      int win = 0;
      #1;
      for (int s = 0; s < N; s++) begin
         if (m_pend[s] && m_pri[s] > best) begin
            best = m_pri[s];
            win = s;
         end
      end
      e.tag    = tag;
      e.valid  = (best >= 0);
      e.code   = (best >= 0) ? exp_code(win) : 12'h000;
      e.irq    = (best >= 0) && !cpu_block && (int'(cpu_mask) < best);
      e.chk_rd = 1'b1;
      e.rd     = exp_rd(bus_addr);
      sb.push_back(e);
   endtask

   task automatic raise(input int s);
      @(negedge clk);
      src_raise[s] = 1'b1;
      if (m_pri[s] != 0) m_pend[s] = 1'b1;
      @(negedge clk);
      src_raise = '0;
   endtask

   task automatic clear(input int s);
      @(negedge clk);
      src_clear[s] = 1'b1;
      m_pend[s] = 1'b0;
      @(negedge clk);
      src_clear = '0;
   endtask

   task automatic raise_and_clear(input int s);
      @(negedge clk);
      src_raise[s] = 1'b1;
      src_clear[s] = 1'b1;
      m_pend[s] = 1'b0;
      @(negedge clk);
      src_raise = '0;
      src_clear = '0;
   endtask

   task automatic write_reg(input logic [31:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      case (a[11:0])
         12'h004: m_reg[0] = d;
         12'h008: m_reg[1] = d;
         12'h00C: m_reg[2] = d;
         default: ;
      endcase
      apply_regs();
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic set_cpu(input logic [3:0] m, input logic b);
      @(negedge clk);
      cpu_mask = m;
      cpu_block = b;
   endtask

   task automatic set_addr(input logic [31:0] a);
      @(negedge clk);
      bus_addr = a;
   endtask

   // monitor: pops expected items and compares with the outputs
   initial begin
      forever begin
         exp_t e;
         wait (sb.size() > 0);
         e = sb.pop_front();
         checks++;
         if (win_valid !== e.valid || win_code !== e.code || irq_req !== e.irq ||
             (e.chk_rd && bus_rdata !== e.rd)) begin
            errors++;
            $display("FAIL %s: valid=%0b code=%h irq=%0b rd=%h expected valid=%0b code=%h irq=%0b rd=%h",
                     e.tag, win_valid, win_code, irq_req, bus_rdata,
                     e.valid, e.code, e.irq, e.rd);
         end
      end
   end

   initial begin
      for (int s = 0; s < N; s++) begin
         m_pend[s] = 1'b0;
         m_pri[s]  = (s < 15) ? 15 - s : (s == 15 ? 16 : 0);
      end
      for (int k = 0; k < 3; k++) m_reg[k] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      set_addr(32'h0000_0004); check("R8 R11 reset, reg A reads 0");
      set_addr(32'h0000_0008); check("R8 reset, reg B reads 0");
      set_addr(32'h0000_000C); check("R8 reset, reg C reads 0");

      // external lines, default levels and codes
      raise(3);                check("R7 ext line 3 code");
      raise(1);                check("R5 ext line 1 outranks 3");
      set_cpu(4'd14, 1'b0);    check("R6 mask equal to level blocks");
      set_cpu(4'd13, 1'b0);    check("R6 mask below level requests");
      set_cpu(4'd0, 1'b1);     check("R6 block bit gates request");
      set_cpu(4'd15, 1'b0);    check("R6 mask 15 over level 14");
      raise(15);               check("R8 NMI level 16 beats mask 15, R7 code");
      raise(15);               check("R9 second NMI raise");
      clear(15);               check("R9 one clear removes NMI");
      set_cpu(4'd0, 1'b0);
      clear(1);                check("R9 clear ext 1");
      clear(3);                check("R11 nothing pending");

      // masked source
      raise(23);               check("R1 level 0 timer 0 not recorded");
      write_reg(32'h0000_3004, 16'h5678);
      set_addr(32'h0000_0004); check("R1 R10 alias write to A, still not pending");

      // register A groups
      raise(23);
      raise(28);               check("R2 clock source level 8 beats timer 0 level 5");
      clear(28);               check("R2 timer 0 after clock clear");
      clear(23);
      write_reg(32'h0000_0004, 16'h3333);
      raise(26);
      raise(24);               check("R5 equal level, lower index 24 wins");
      raise(25);               check("R5 R2 timer 2 shares level, 24 still wins");
      clear(24);               check("R5 25 wins over 26");
      clear(25);
      clear(26);

      // register B groups and reserved nibble
      write_reg(32'hFF00_1008, 16'hABCF);
      set_addr(32'h0000_0008); check("R10 R3 read back B including reserved bits");
      raise(38);
      raise(33);               check("R3 serial level 12 beats watchdog 10");
      clear(33);
      raise(40);               check("R3 refresh level 11 beats watchdog");
      clear(40);
      clear(38);               check("R3 empty after clears");

      // register C groups
      write_reg(32'h0000_000C, 16'h1234);
      set_addr(32'h0000_0010); check("R10 unmapped offset reads 0");
      raise(22);
      raise(35);
      raise(16);               check("R4 debug port level 4 wins");
      clear(16);               check("R4 FIFO serial level 3 next");
      clear(35);               check("R4 DMA error level 2 next");
      raise(17);               check("R4 GPIO level 1 loses to DMA error");
      clear(22);               check("R4 GPIO alone");
      clear(17);

      // same-cycle raise and clear
      raise_and_clear(18);     check("R9 clear wins over raise");

      @(negedge clk);
      wait (sb.size() == 0);
      #1;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule